// File: doc/BRIEF.md
# ADC Start-Trigger and Track/Convert Sequencer

This block is the control logic beside a successive-approximation converter. Host-held control levels choose whether the converter runs, which of four start events begins a conversion, whether the sampler tracks all the time or only for a short phase before each conversion, and how the finished result sits in a 16-bit high/low result pair. The analog sampler and the bit-trial logic are not part of the block. A conversion is modelled as a count of SAR clock ticks. A word supplied on `sar_result` is captured when the count ends.

The SAR clock is a clock-enable pulse divided down from the system clock. The divider holds its phase while the sequencer is idle, so every sequence takes an exact, known number of system cycles. Timer overflows arrive as one-cycle pulses. The external start pin is an asynchronous level. A software start is a one-cycle pulse that stands for a host write of 1 to the busy bit; a host write of 0 produces no pulse.

Top module: `adc_seq_ctrl`

## Requirements
- R1: While `cfg_en` is 0, no start event of any source raises `busy`, and `tracking` is 0. Dropping `cfg_en` during a sequence returns `busy` to 0 at the next clock edge without setting `done_flag`.
- R2: `cfg_src` picks the only start source that is honoured. 2'b00 is `sw_start`, 2'b01 is `tmr3_ovf`, 2'b10 is a rising edge of `ext_start`, and 2'b11 is `tmr2_ovf`. Events from the other three sources do not raise `busy`.
- R3: With `cfg_lptrack`=0, `tracking` is 1 while the block is enabled and idle. A pulse start raises `busy` at the first clock edge that samples it. `busy` then stays high for exactly RES_W*SAR_DIV cycles.
- R4: With `cfg_lptrack`=1 and `cfg_src` set to 00, 01 or 11, `busy` stays high for (3+RES_W)*SAR_DIV cycles. `tracking` is high during exactly the first 3*SAR_DIV of those cycles.
- R5: With `cfg_lptrack`=1 and `cfg_src`=2'b10, `tracking` follows the inverted, synchronised pin while the block is idle. The rising edge starts conversion with no tracking phase, so `busy` lasts RES_W*SAR_DIV cycles.
- R6: `ext_start` passes through a two-flop synchroniser before edge detection. `busy` rises at the third clock edge that samples the pin high.
- R7: `done_flag` is set at the same edge at which `busy` falls on completion. It stays set until `done_clr`. A completion in the same cycle as `done_clr` leaves the flag set.
- R8: With `cfg_ljust`=0, the captured RES_W-bit result sits in bits [RES_W-1:0] of {`res_hi`,`res_lo`}, with zeros above. With `cfg_ljust`=1, it sits in bits [15:16-RES_W], with zeros below. The format follows `cfg_ljust` without a new conversion.
- R9: A start event that arrives while `busy` is 1 is dropped and is not queued. The running sequence keeps its length, and no second sequence follows it.
- R10: After reset, `busy`, `done_flag` and both result bytes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_en | input | 1 | Converter enable |
| cfg_lptrack | input | 1 | 1 selects low-power (phased) tracking |
| cfg_src | input | 2 | Start source select |
| cfg_ljust | input | 1 | 1 selects left-justified result |
| sw_start | input | 1 | One-cycle software start pulse |
| done_clr | input | 1 | Clears the completion flag |
| tmr3_ovf | input | 1 | Timer-3 overflow pulse |
| tmr2_ovf | input | 1 | Timer-2 overflow pulse |
| ext_start | input | 1 | Asynchronous external start pin |
| sar_result | input | RES_W | Result word captured at completion |
| busy | output | 1 | Sequence in progress |
| done_flag | output | 1 | Conversion complete, sticky |
| tracking | output | 1 | Sampler tracking request |
| res_hi | output | 8 | Result high byte |
| res_lo | output | 8 | Result low byte |

## Verification
A wrong state or tick count inside the sequencer shows up at once as a `busy` pulse of the wrong length, which the bench measures to the cycle for every mode and source. A wrong phase shows up as a `tracking` high time other than 3*SAR_DIV or 0. A broken source decoder or synchroniser appears within three cycles of the stimulus, either as a wrong start latency or as a start that should not have happened. A capture or format fault shows in `res_hi`/`res_lo` on the cycle after `busy` falls.

// File: rtl/adc_seq_pkg.sv
// Package: shared types of the ADC start/track/convert sequencer.
// Assumes: the start-source encoding is fixed by the host control field.
package adc_seq_pkg;

    typedef enum logic [1:0] {
        SRC_SW  = 2'b00,
        SRC_T3  = 2'b01,
        SRC_PIN = 2'b10,
        SRC_T2  = 2'b11
    } start_src_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_TRACK = 2'b01,
        ST_CONV  = 2'b10
    } seq_state_e;

endpackage

// File: rtl/sar_tick_gen.sv
// Module: sar_tick_gen
// Divides the system clock into a one-cycle SAR clock enable.
// Assumes: the phase restarts whenever run is low, so the first tick comes
// exactly DIV cycles after run rises.
module sar_tick_gen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_pass
            // Purpose: every cycle is a SAR tick.
            assign tick = run;
        end else begin : g_div
            localparam int CW = $clog2(DIV);
            localparam logic [CW-1:0] LAST = CW'(DIV - 1);
            logic [CW-1:0] cnt_q;

            // Purpose: free-running divider count, held at 0 while idle.
            always_ff @(posedge clk) begin
                if (!rst_n || !run) begin
                    cnt_q <= '0;
                end else if (cnt_q == LAST) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end

            assign tick = run && (cnt_q == LAST);

            // R3: ticks are spaced by DIV cycles, never back to back
            p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick)
                else $error("SAR ticks on consecutive cycles");
        end
    endgenerate
endmodule

// File: rtl/start_select.sv
// Module: start_select
// Synchronises the external start pin, finds its rising edge, and picks the
// start event named by the source select.
// Assumes: timer and software starts are already one-cycle synchronous pulses.
module start_select
    import adc_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  start_src_e src,
    input  logic       sw_start,
    input  logic       tmr3_ovf,
    input  logic       tmr2_ovf,
    input  logic       ext_pin,
    output logic       start_evt,
    output logic       pin_level
);
    logic sync1_q, sync2_q, prev_q;
    logic pin_rise;

    // Purpose: two-flop synchroniser plus one delay flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
            prev_q  <= 1'b0;
        end else begin
            sync1_q <= ext_pin;
            sync2_q <= sync1_q;
            prev_q  <= sync2_q;
        end
    end

    assign pin_rise  = sync2_q && !prev_q;
    assign pin_level = sync2_q;

    // Purpose: multiplex the selected source and gate it with the enable.
    always_comb begin
        unique case (src)
            SRC_SW:  start_evt = sw_start;
            SRC_T3:  start_evt = tmr3_ovf;
            SRC_PIN: start_evt = pin_rise;
            SRC_T2:  start_evt = tmr2_ovf;
            default: start_evt = 1'b0;
        endcase
        start_evt = start_evt && en;
    end

    // R6: an edge is only reported after the pin has been seen high twice
    p_rise_after_two_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pin_rise |-> $past(sync1_q))
        else $error("pin edge without synchronised history");
endmodule

// File: rtl/seq_fsm.sv
// Module: seq_fsm
// Idle / track / convert sequencer with the sticky completion flag.
// Assumes: tick is a one-cycle enable whose phase restarts when the FSM
// leaves idle; start_evt is already gated by the enable.
module seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int RES_W       = 10,
    parameter int TRACK_TICKS = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       lptrack,
    input  start_src_e src,
    input  logic       start_evt,
    input  logic       tick,
    input  logic       pin_level,
    input  logic       done_clr,
    output logic       run,
    output logic       busy,
    output logic       tracking,
    output logic       capture,
    output logic       done
);
    localparam int MAXT = (RES_W > TRACK_TICKS) ? RES_W : TRACK_TICKS;
    localparam int CW   = $clog2(MAXT + 1);
    localparam logic [CW-1:0] TRK_LAST = CW'(TRACK_TICKS - 1);
    localparam logic [CW-1:0] CNV_LAST = CW'(RES_W - 1);

    seq_state_e state_q;
    logic [CW-1:0] cnt_q;
    logic phased;

    assign phased  = lptrack && (src != SRC_PIN);
    assign capture = en && (state_q == ST_CONV) && tick && (cnt_q == CNV_LAST);
    assign run     = (state_q != ST_IDLE);
    assign busy    = run;

    // Purpose: advance the phase state and its tick count.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    cnt_q <= '0;
                    if (start_evt) begin
                        state_q <= phased ? ST_TRACK : ST_CONV;
                    end
                end
                ST_TRACK: begin
                    if (tick) begin
                        if (cnt_q == TRK_LAST) begin
                            cnt_q   <= '0;
                            state_q <= ST_CONV;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                ST_CONV: begin
                    if (tick) begin
                        if (cnt_q == CNV_LAST) begin
                            cnt_q   <= '0;
                            state_q <= ST_IDLE;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                    cnt_q   <= '0;
                end
            endcase
        end
    end

    // Purpose: sticky completion flag; a completion wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
        end else if (capture) begin
            done <= 1'b1;
        end else if (done_clr) begin
            done <= 1'b0;
        end
    end

    // Purpose: tracking request for the sampler in each track mode.
    always_comb begin
        if (!en) begin
            tracking = 1'b0;
        end else if (!lptrack) begin
            tracking = (state_q == ST_IDLE);
        end else if (src == SRC_PIN) begin
            tracking = (state_q == ST_IDLE) && !pin_level;
        end else begin
            tracking = (state_q == ST_TRACK);
        end
    end

    // R1: a disabled converter is idle on the next cycle
    p_off_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !busy)
        else $error("busy while disabled");

    // R7: completion flag only rises as busy falls
    p_done_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $fell(busy))
        else $error("done set without busy falling");

    // R7: flag holds until cleared
    p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !done_clr) |=> done)
        else $error("done dropped without clear");

    // R2: a sequence starts only from a selected, enabled event
    p_start_from_event_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start_evt))
        else $error("sequence started without event");

    // R5: the pin source never uses the fixed tracking phase
    p_pin_no_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lptrack && src == SRC_PIN && $stable(src) && $stable(lptrack) && !$past(run))
            |-> state_q != ST_TRACK)
        else $error("pin source entered tracking phase");
endmodule

// File: rtl/result_fmt.sv
// Module: result_fmt
// Captures the converter word at completion and presents it right- or
// left-justified as a high and low byte.
// Assumes: RES_W <= OUT_W and OUT_W is even.
module result_fmt #(
    parameter int RES_W = 10,
    parameter int OUT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               capture,
    input  logic [RES_W-1:0]   raw_in,
    input  logic               ljust,
    output logic [OUT_W/2-1:0] res_hi,
    output logic [OUT_W/2-1:0] res_lo
);
    localparam int PAD  = OUT_W - RES_W;
    localparam int HALF = OUT_W / 2;

    logic [RES_W-1:0] raw_q;
    logic [OUT_W-1:0] wide, word;

    // Purpose: hold the last completed result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q <= '0;
        end else if (capture) begin
            raw_q <= raw_in;
        end
    end

    // Purpose: zero-extend, then shift up for left justification.
    always_comb begin
        wide = '0;
        wide[RES_W-1:0] = raw_q;
        word = ljust ? (wide << PAD) : wide;
    end

    assign res_hi = word[OUT_W-1:HALF];
    assign res_lo = word[HALF-1:0];

    // R8: right-justified output carries no bits above the result width
    p_right_pad_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ljust |-> ({res_hi, res_lo} >> RES_W) == '0)
        else $error("right-justified result has high bits set");
endmodule

// File: rtl/adc_seq_ctrl.sv
// Module: adc_seq_ctrl (top)
// Start-trigger selection, track/convert sequencing and result formatting
// for a successive-approximation converter.
// Assumes: control levels come from a host register held elsewhere;
// sw_start is the one-cycle pulse of a host write of 1 to the busy bit.
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int RES_W       = 10,
    parameter int OUT_W       = 16,
    parameter int SAR_DIV     = 4,
    parameter int TRACK_TICKS = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_en,
    input  logic               cfg_lptrack,
    input  logic [1:0]         cfg_src,
    input  logic               cfg_ljust,
    input  logic               sw_start,
    input  logic               done_clr,
    input  logic               tmr3_ovf,
    input  logic               tmr2_ovf,
    input  logic               ext_start,
    input  logic [RES_W-1:0]   sar_result,
    output logic               busy,
    output logic               done_flag,
    output logic               tracking,
    output logic [OUT_W/2-1:0] res_hi,
    output logic [OUT_W/2-1:0] res_lo
);
    start_src_e src;
    logic start_evt, pin_level, run, tick, capture;

    assign src = start_src_e'(cfg_src);

    start_select u_src (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (cfg_en),
        .src       (src),
        .sw_start  (sw_start),
        .tmr3_ovf  (tmr3_ovf),
        .tmr2_ovf  (tmr2_ovf),
        .ext_pin   (ext_start),
        .start_evt (start_evt),
        .pin_level (pin_level)
    );

    sar_tick_gen #(.DIV(SAR_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    seq_fsm #(.RES_W(RES_W), .TRACK_TICKS(TRACK_TICKS)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (cfg_en),
        .lptrack   (cfg_lptrack),
        .src       (src),
        .start_evt (start_evt),
        .tick      (tick),
        .pin_level (pin_level),
        .done_clr  (done_clr),
        .run       (run),
        .busy      (busy),
        .tracking  (tracking),
        .capture   (capture),
        .done      (done_flag)
    );

    result_fmt #(.RES_W(RES_W), .OUT_W(OUT_W)) u_fmt (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .raw_in  (sar_result),
        .ljust   (cfg_ljust),
        .res_hi  (res_hi),
        .res_lo  (res_lo)
    );
endmodule

// File: tb/tb_adc_seq_ctrl.sv
`timescale 1ns/1ps
module tb_adc_seq_ctrl;
    localparam int RES_W = 10;
    localparam int DIV   = 4;
    localparam int TRK   = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_en = 0, cfg_lptrack = 0, cfg_ljust = 0;
    logic [1:0] cfg_src = 0;
    logic sw_start = 0, done_clr = 0, tmr3_ovf = 0, tmr2_ovf = 0, ext_start = 0;
    logic [RES_W-1:0] sar_result = '0;
    logic busy, done_flag, tracking;
    logic [7:0] res_hi, res_lo;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    adc_seq_ctrl #(.RES_W(RES_W), .OUT_W(16), .SAR_DIV(DIV), .TRACK_TICKS(TRK)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_lptrack(cfg_lptrack),
        .cfg_src(cfg_src), .cfg_ljust(cfg_ljust), .sw_start(sw_start),
        .done_clr(done_clr), .tmr3_ovf(tmr3_ovf), .tmr2_ovf(tmr2_ovf),
        .ext_start(ext_start), .sar_result(sar_result), .busy(busy),
        .done_flag(done_flag), .tracking(tracking), .res_hi(res_hi), .res_lo(res_lo)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Drive the start source s; pin is raised and left high. Returns the
    // number of negedges until busy is seen (0 if not within limit).
    task automatic fire(input int s, input int limit, output int lat);
        @(negedge clk);
        case (s)
            0: sw_start = 1;
            1: tmr3_ovf = 1;
            2: ext_start = 1;
            default: tmr2_ovf = 1;
        endcase
        lat = 0;
        for (int i = 1; i <= limit; i++) begin
            @(negedge clk);
            sw_start = 0; tmr3_ovf = 0; tmr2_ovf = 0;
            if (busy && lat == 0) lat = i;
        end
    endtask

    // Count busy and tracking-during-busy cycles until busy falls.
    task automatic measure(output int blen, output int tlen);
        blen = 0; tlen = 0;
        while (busy && blen < 1000) begin
            blen++;
            if (tracking) tlen++;
            @(negedge clk);
        end
    endtask

    task automatic pulse_clr();
        @(negedge clk); done_clr = 1;
        @(negedge clk); done_clr = 0;
    endtask

    // Fire a pulse source with latency 1 and return with busy already high
    task automatic start_sw();
        @(negedge clk); sw_start = 1;
        @(negedge clk); sw_start = 0;
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        finish_run();
    end

    initial begin
        int lat, blen, tlen, v, exp_full;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 busy in reset", busy, 0);
        chk("R10 done in reset", done_flag, 0);
        rst_n = 1;
        @(negedge clk);
        chk("R10 busy after reset", busy, 0);
        chk("R10 done after reset", done_flag, 0);
        chk("R10 result after reset", {res_hi, res_lo}, 0);
        chk("R1 tracking while disabled", tracking, 0);

        // R1: disabled converter ignores every source
        for (int s = 0; s < 4; s++) begin
            cfg_src = 2'(s);
            fire(s, 6, lat);
            chk("R1 start ignored while disabled", lat, 0);
            ext_start = 0;
            repeat (4) @(negedge clk);
        end

        // Sweep track mode, source and justification
        cfg_en = 1;
        for (int lp = 0; lp < 2; lp++) begin
            for (int s = 0; s < 4; s++) begin
                for (int lj = 0; lj < 2; lj++) begin
                    @(negedge clk);
                    cfg_lptrack = 1'(lp); cfg_src = 2'(s); cfg_ljust = 1'(lj);
                    v = ((lp * 8 + s * 2 + lj) * 37 + 5) % (1 << RES_W);
                    sar_result = RES_W'(v);
                    @(negedge clk);
                    // R3/R5: idle tracking level
                    chk("R3/R5 idle tracking", tracking, (lp == 0 || s == 2) ? 1 : 0);
                    fire(s, (s == 2) ? 3 : 1, lat);
                    chk("R6/R3 start latency", lat, (s == 2) ? 3 : 1);
                    measure(blen, tlen);
                    chk("R3/R4/R5 busy length", blen,
                        (lp == 1 && s != 2) ? (TRK + RES_W) * DIV : RES_W * DIV);
                    chk("R4 tracking phase length", tlen,
                        (lp == 1 && s != 2) ? TRK * DIV : 0);
                    chk("R7 done after completion", done_flag, 1);
                    exp_full = (lj == 1) ? (v << (16 - RES_W)) : v;
                    chk("R8 result high byte", res_hi, (exp_full >> 8) & 255);
                    chk("R8 result low byte", res_lo, exp_full & 255);
                    ext_start = 0;
                    pulse_clr();
                    chk("R7 done cleared", done_flag, 0);
                    repeat (3) @(negedge clk);
                end
            end
        end

        // R8: format follows justify bit without a new conversion
        cfg_ljust = 1;
        @(negedge clk);
        chk("R8 live left justify", {res_hi, res_lo}, v << (16 - RES_W));
        cfg_ljust = 0;
        @(negedge clk);
        chk("R8 live right justify", {res_hi, res_lo}, v);

        // R2: with timer-3 selected, other sources do nothing
        cfg_lptrack = 0; cfg_src = 2'b01;
        fire(0, 4, lat); chk("R2 software start ignored in timer-3 mode", lat, 0);
        fire(3, 4, lat); chk("R2 timer-2 ignored in timer-3 mode", lat, 0);
        fire(2, 6, lat); chk("R2 pin ignored in timer-3 mode", lat, 0);
        ext_start = 0;
        cfg_src = 2'b11;
        fire(1, 4, lat); chk("R2 timer-3 ignored in timer-2 mode", lat, 0);
        repeat (4) @(negedge clk);

        // R9: retrigger during a sequence is dropped and not queued
        cfg_src = 2'b00;
        start_sw();
        repeat (5) @(negedge clk);
        sw_start = 1; @(negedge clk); sw_start = 0;
        blen = 6;
        while (busy && blen < 1000) begin blen++; @(negedge clk); end
        chk("R9 length unchanged by retrigger", blen, RES_W * DIV);
        tlen = 0;
        for (int i = 0; i < 20; i++) begin
            if (busy) tlen++;
            @(negedge clk);
        end
        chk("R9 no queued second sequence", tlen, 0);

        // R7: flag holds without clear; completion beats a simultaneous clear
        repeat (30) @(negedge clk);
        chk("R7 done holds", done_flag, 1);
        pulse_clr();
        @(negedge clk); done_clr = 1;
        start_sw();
        done_clr = 1;
        while (busy) @(negedge clk);
        chk("R7 set wins over clear", done_flag, 1);
        @(negedge clk);
        chk("R7 clear after completion", done_flag, 0);
        done_clr = 0;

        // R1: disabling mid-sequence aborts without completion
        sar_result = RES_W'(1);
        start_sw();
        repeat (8) @(negedge clk);
        cfg_en = 0;
        @(negedge clk);
        chk("R1 abort drops busy", busy, 0);
        chk("R1 abort leaves done clear", done_flag, 0);
        chk("R1 abort keeps old result", {res_hi, res_lo}, v);
        cfg_en = 1;
        repeat (2) @(negedge clk);

        finish_run();
    end
endmodule